// File: doc/BRIEF.md
# Bank-Typed Packed SIMD Execution Unit

This block pairs a 32-entry, 32-bit register file with a packed arithmetic unit. The instruction does not say how wide or how signed its lanes are. The register numbers say it. The same "halving add" or "add" operation runs as a signed or an unsigned 16-bit lane operation, depending on which bank the three registers come from. Registers 16 to 23 hold two signed 16-bit lanes and registers 24 to 29 hold two unsigned 16-bit lanes. Registers 2 to 7 are signed byte vectors, registers 8 to 15 are unsigned byte vectors, and registers 30 and 31 hold one signed word. Register 1 is kept for predicate masks. Register 0 is a constant zero.

An operation has an operation select, a 2-bit mode and three register indices: a destination and two sources. The two sources are read combinationally. The result goes to the destination on the next rising clock edge, but only if the combination of indices and mode is legal for that operation. An illegal combination raises a one-cycle flag instead and writes nothing. A separate fill port shares the single write port, so that a memory side can load register contents. The same index ports read the registers out.

Top module: `simd_exec`

## Requirements
- R1: Register 0 always reads as zero. A write to it, from the fill port or from an operation, is discarded.
- R2: Select 0 with mode 0 and all three indices in 16..23 writes, for each lane, the signed halving add: (a+b)>>1 computed with one extra bit and an arithmetic shift. Lane 0 is bits 15:0 and lane 1 is bits 31:16.
- R3: Select 0 with mode 0 and all three indices in 24..29 writes, for each lane, the unsigned halving add: (a+b)>>1 computed with one extra bit and a logical shift.
- R4: Select 1 with mode 1 and all indices in 16..23 writes the signed saturating add, clamped to [-32768, 32767] per lane.
- R5: Select 1 with mode 1 and all indices in 24..29 writes the unsigned saturating add, clamped to [0, 65535] per lane.
- R6: Select 2 with mode 0 and all three indices anywhere in 16..29 (banks may be mixed) writes the per-lane wrapping difference a-b.
- R7: A valid operation is illegal in any of these cases: its indices fall outside the range allowed for that select and mode, or its mode does not match the select, or its select is 3. An illegal operation sets illegalOut high for exactly the cycle after its clock edge and leaves the destination unchanged. A legal operation leaves illegalOut low.
- R8: With opValid low, no operation result is written and illegalOut stays low.
- R9: rdataA and rdataB show the indexed register combinationally. During the cycle in which a register is being written, they show its old value. They show the new value after the edge.
- R10: loadEn writes loadData to loadIdx on the clock edge. If a legal operation writes in the same cycle, the operation wins and the fill is dropped. An illegal operation does not block the fill.
- R11: Lanes are computed independently, so no borrow or carry crosses from lane 0 into lane 1.
- R12: After reset, every register reads zero and illegalOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation strobe |
| opSel | input | 2 | 0 halving add, 1 add, 2 subtract, 3 reserved |
| opMode | input | 2 | Mode field |
| rtIdx | input | 5 | Destination register |
| raIdx | input | 5 | First source register / read-out index A |
| rbIdx | input | 5 | Second source register / read-out index B |
| loadEn | input | 1 | Fill port write strobe |
| loadIdx | input | 5 | Fill port register index |
| loadData | input | 32 | Fill port data |
| rdataA | output | 32 | Combinational content of raIdx |
| rdataB | output | 32 | Combinational content of rbIdx |
| illegalOut | output | 1 | One-cycle illegal-combination flag |

## Verification
Two events can fall in the same cycle: an operation write and a fill-port write that compete for the one write port. The bench provokes this by raising loadEn together with a legal operation that targets the same register, then reading that register back. It expects the operation result. It then repeats the collision with an illegal operation and expects the fill data to land. A second overlap is a destination that is also a source. There the bench samples rdataA before the edge and expects the old content, then samples after the edge and expects the new one.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int NREG = 32;
  localparam int DW   = 32;
  localparam int LW   = 16;
  localparam int IW   = $clog2(NREG);
  localparam int LANES = DW / LW;

  localparam int S16_LO = 16;
  localparam int S16_HI = 23;
  localparam int U16_LO = 24;
  localparam int U16_HI = 29;

  localparam logic [1:0] SEL_HADD = 2'd0;
  localparam logic [1:0] SEL_ADD  = 2'd1;
  localparam logic [1:0] SEL_SUB  = 2'd2;

  localparam logic [1:0] MODE_HADD = 2'd0;
  localparam logic [1:0] MODE_ADD  = 2'd1;
  localparam logic [1:0] MODE_SUB  = 2'd0;

  typedef enum logic [1:0] {
    ALU_HALF = 2'd0,
    ALU_SAT  = 2'd1,
    ALU_SUB  = 2'd2
  } aluSel_e;

  typedef struct packed {
    logic    writeEn;
    logic    isSigned;
    aluSel_e aluSel;
  } ctrl_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [1:0]    opSel,
  input  logic [1:0]    opMode,
  input  logic [IW-1:0] rtIdx,
  input  logic [IW-1:0] raIdx,
  input  logic [IW-1:0] rbIdx,
  output ctrl_t         ctrl,
  output logic          illegalQ
);
  function automatic logic inRange(input logic [IW-1:0] idx, input int lo, input int hi);
    return (int'(idx) >= lo) && (int'(idx) <= hi);
  endfunction

  logic allS, allU, all16, legal;

  always_comb begin
    allS  = inRange(rtIdx, S16_LO, S16_HI) && inRange(raIdx, S16_LO, S16_HI)
         && inRange(rbIdx, S16_LO, S16_HI);
    allU  = inRange(rtIdx, U16_LO, U16_HI) && inRange(raIdx, U16_LO, U16_HI)
         && inRange(rbIdx, U16_LO, U16_HI);
    all16 = inRange(rtIdx, S16_LO, U16_HI) && inRange(raIdx, S16_LO, U16_HI)
         && inRange(rbIdx, S16_LO, U16_HI);
    legal = 1'b0;
    ctrl.aluSel = ALU_HALF;
    unique case (opSel)
      SEL_HADD: begin
        legal = (opMode == MODE_HADD) && (allS || allU);
        ctrl.aluSel = ALU_HALF;
      end
      SEL_ADD: begin
        legal = (opMode == MODE_ADD) && (allS || allU);
        ctrl.aluSel = ALU_SAT;
      end
      SEL_SUB: begin
        legal = (opMode == MODE_SUB) && all16;
        ctrl.aluSel = ALU_SUB;
      end
      default: legal = 1'b0;
    endcase
    ctrl.isSigned = allS;
    ctrl.writeEn  = opValid && legal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) illegalQ <= 1'b0;
    else       illegalQ <= opValid && !legal;
  end
endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_t         ctrl,
  input  logic [IW-1:0] rtIdx,
  input  logic [IW-1:0] raIdx,
  input  logic [IW-1:0] rbIdx,
  input  logic          loadEn,
  input  logic [IW-1:0] loadIdx,
  input  logic [DW-1:0] loadData,
  output logic [DW-1:0] rdataA,
  output logic [DW-1:0] rdataB
);
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] result;

  assign rdataA = (raIdx == '0) ? '0 : regs[raIdx];
  assign rdataB = (rbIdx == '0) ? '0 : regs[rbIdx];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] a, b, diff, half, sat;
    logic [LW:0]   ea, eb, sum;
    assign a    = rdataA[l*LW +: LW];
    assign b    = rdataB[l*LW +: LW];
    assign ea   = {ctrl.isSigned & a[LW-1], a};
    assign eb   = {ctrl.isSigned & b[LW-1], b};
    assign sum  = ea + eb;
    assign diff = a - b;
    assign half = sum[LW:1];
    always_comb begin
      if (ctrl.isSigned) begin
        if (sum[LW] != sum[LW-1])
          sat = sum[LW] ? {1'b1, {(LW-1){1'b0}}} : {1'b0, {(LW-1){1'b1}}};
        else
          sat = sum[LW-1:0];
      end else begin
        sat = sum[LW] ? {LW{1'b1}} : sum[LW-1:0];
      end
    end
    always_comb begin
      unique case (ctrl.aluSel)
        ALU_HALF: result[l*LW +: LW] = half;
        ALU_SAT:  result[l*LW +: LW] = sat;
        default:  result[l*LW +: LW] = diff;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (ctrl.writeEn) begin
      if (rtIdx != '0) regs[rtIdx] <= result;
    end else if (loadEn) begin
      if (loadIdx != '0) regs[loadIdx] <= loadData;
    end
  end
endmodule

// File: rtl/simd_exec.sv
module simd_exec
  import simd_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [1:0]    opSel,
  input  logic [1:0]    opMode,
  input  logic [IW-1:0] rtIdx,
  input  logic [IW-1:0] raIdx,
  input  logic [IW-1:0] rbIdx,
  input  logic          loadEn,
  input  logic [IW-1:0] loadIdx,
  input  logic [DW-1:0] loadData,
  output logic [DW-1:0] rdataA,
  output logic [DW-1:0] rdataB,
  output logic          illegalOut
);
  ctrl_t ctrl;

  simd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .opMode(opMode),
    .rtIdx(rtIdx), .raIdx(raIdx), .rbIdx(rbIdx), .ctrl(ctrl), .illegalQ(illegalOut)
  );

  simd_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .rtIdx(rtIdx), .raIdx(raIdx), .rbIdx(rbIdx),
    .loadEn(loadEn), .loadIdx(loadIdx), .loadData(loadData),
    .rdataA(rdataA), .rdataB(rdataB)
  );
endmodule

// File: rtl/simd_exec_chk.sv
module simd_exec_chk
  import simd_pkg::*;
(
  input logic          clk,
  input logic          rstN,
  input logic          opValid,
  input logic [1:0]    opSel,
  input logic          loadEn,
  input logic [IW-1:0] raIdx,
  input logic [DW-1:0] rdataA,
  input logic          illegalOut
);
  // R7
  illegal_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> $past(opValid));

  // R7
  reserved_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSel == 2'd3) |=> illegalOut);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !illegalOut);

  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !loadEn) |=> (raIdx != $past(raIdx)) || (rdataA == $past(rdataA)));
endmodule

bind simd_exec simd_exec_chk u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .loadEn(loadEn),
  .raIdx(raIdx), .rdataA(rdataA), .illegalOut(illegalOut)
);

// File: tb/tb_simd_exec.sv
module tb_simd_exec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [1:0]  opSel = '0;
  logic [1:0]  opMode = '0;
  logic [4:0]  rtIdx = '0, raIdx = '0, rbIdx = '0;
  logic        loadEn = 1'b0;
  logic [4:0]  loadIdx = '0;
  logic [31:0] loadData = '0;
  logic [31:0] rdataA, rdataB;
  logic        illegalOut;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  simd_exec dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .opMode(opMode),
    .rtIdx(rtIdx), .raIdx(raIdx), .rbIdx(rbIdx), .loadEn(loadEn), .loadIdx(loadIdx),
    .loadData(loadData), .rdataA(rdataA), .rdataB(rdataB), .illegalOut(illegalOut)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic loadReg(input logic [4:0] idx, input logic [31:0] data);
    @(negedge clk);
    loadEn = 1'b1; loadIdx = idx; loadData = data;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic readReg(input logic [4:0] idx, output logic [31:0] val);
    @(negedge clk);
    opValid = 1'b0; raIdx = idx;
    #1 val = rdataA;
  endtask

  task automatic doOp(input logic [1:0] sel, input logic [1:0] mode,
                      input logic [4:0] rt, input logic [4:0] ra, input logic [4:0] rb,
                      output logic ill);
    @(negedge clk);
    opValid = 1'b1; opSel = sel; opMode = mode; rtIdx = rt; raIdx = ra; rbIdx = rb;
    @(negedge clk);
    opValid = 1'b0;
    #1 ill = illegalOut;
  endtask

  task automatic expectReg(input string tag, input logic [4:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    readReg(idx, v);
    check(tag, v, exp);
  endtask

  task automatic testReset();
    expectReg("R12 reg17", 5'd17, 32'h0);
    expectReg("R12 reg31", 5'd31, 32'h0);
    check("R12 illegal", {31'b0, illegalOut}, 32'h0);
  endtask

  task automatic testZeroReg();
    logic ill;
    loadReg(5'd0, 32'hFFFF_FFFF);
    expectReg("R1 fill to r0", 5'd0, 32'h0);
    doOp(2'd2, 2'd0, 5'd0, 5'd16, 5'd17, ill);
    expectReg("R1 op to r0", 5'd0, 32'h0);
  endtask

  task automatic fillAll();
    loadReg(5'd16, 32'h7FFF_8000);
    loadReg(5'd17, 32'h0001_8000);
    loadReg(5'd19, 32'hFFFF_0003);
    loadReg(5'd20, 32'h0000_0004);
    loadReg(5'd24, 32'hFFFF_0001);
    loadReg(5'd25, 32'hFFFF_0002);
    loadReg(5'd29, 32'h0000_0000);
  endtask

  task automatic testHalving();
    logic ill;
    doOp(2'd0, 2'd0, 5'd18, 5'd16, 5'd17, ill);
    check("R2 legal flag", {31'b0, ill}, 32'h0);
    expectReg("R2 signed extremes", 5'd18, 32'h4000_8000);
    doOp(2'd0, 2'd0, 5'd21, 5'd19, 5'd20, ill);
    expectReg("R2 signed negative", 5'd21, 32'hFFFF_0003);
    doOp(2'd0, 2'd0, 5'd26, 5'd24, 5'd25, ill);
    expectReg("R3 unsigned", 5'd26, 32'hFFFF_0001);
  endtask

  task automatic testSaturate();
    logic ill;
    doOp(2'd1, 2'd1, 5'd22, 5'd16, 5'd17, ill);
    expectReg("R4 signed clamp", 5'd22, 32'h7FFF_8000);
    doOp(2'd1, 2'd1, 5'd23, 5'd19, 5'd20, ill);
    expectReg("R4 signed plain", 5'd23, 32'hFFFF_0007);
    doOp(2'd1, 2'd1, 5'd27, 5'd24, 5'd25, ill);
    expectReg("R5 unsigned clamp", 5'd27, 32'hFFFF_0003);
  endtask

  task automatic testSub();
    logic ill;
    doOp(2'd2, 2'd0, 5'd28, 5'd20, 5'd25, ill);
    check("R6 legal flag", {31'b0, ill}, 32'h0);
    expectReg("R6 mixed banks", 5'd28, 32'h0001_0002);
    doOp(2'd2, 2'd0, 5'd19, 5'd29, 5'd24, ill);
    expectReg("R11 no cross-lane borrow", 5'd19, 32'h0001_FFFF);
  endtask

  task automatic testIllegal();
    logic ill;
    doOp(2'd0, 2'd1, 5'd18, 5'd16, 5'd17, ill);
    check("R7 wrong mode flag", {31'b0, ill}, 32'h1);
    doOp(2'd0, 2'd0, 5'd18, 5'd16, 5'd24, ill);
    check("R7 mixed halving flag", {31'b0, ill}, 32'h1);
    doOp(2'd2, 2'd0, 5'd30, 5'd16, 5'd17, ill);
    check("R7 sub rt out of range", {31'b0, ill}, 32'h1);
    doOp(2'd3, 2'd0, 5'd18, 5'd16, 5'd17, ill);
    check("R7 reserved select", {31'b0, ill}, 32'h1);
    doOp(2'd1, 2'd1, 5'd18, 5'd2, 5'd17, ill);
    check("R7 byte bank source", {31'b0, ill}, 32'h1);
    @(negedge clk);
    check("R7 flag one cycle", {31'b0, illegalOut}, 32'h0);
    expectReg("R7 destination kept", 5'd18, 32'h4000_8000);
  endtask

  task automatic testNoValid();
    @(negedge clk);
    opValid = 1'b0; opSel = 2'd2; opMode = 2'd0; rtIdx = 5'd18; raIdx = 5'd16; rbIdx = 5'd17;
    @(negedge clk);
    check("R8 no flag", {31'b0, illegalOut}, 32'h0);
    expectReg("R8 no write", 5'd18, 32'h4000_8000);
  endtask

  task automatic testReadDuringWrite();
    @(negedge clk);
    opValid = 1'b1; opSel = 2'd0; opMode = 2'd0; rtIdx = 5'd18; raIdx = 5'd18; rbIdx = 5'd17;
    #1 check("R9 old value before edge", rdataA, 32'h4000_8000);
    @(negedge clk);
    opValid = 1'b0;
    #1 check("R9 new value after edge", rdataA, 32'h2000_8000);
  endtask

  task automatic testCollision();
    @(negedge clk);
    opValid = 1'b1; opSel = 2'd2; opMode = 2'd0; rtIdx = 5'd21; raIdx = 5'd20; rbIdx = 5'd25;
    loadEn = 1'b1; loadIdx = 5'd21; loadData = 32'h1234_5678;
    @(negedge clk);
    opValid = 1'b0; loadEn = 1'b0;
    expectReg("R10 operation wins", 5'd21, 32'h0001_0002);
    @(negedge clk);
    opValid = 1'b1; opSel = 2'd3; rtIdx = 5'd29; raIdx = 5'd16; rbIdx = 5'd17;
    loadEn = 1'b1; loadIdx = 5'd29; loadData = 32'hAAAA_5555;
    @(negedge clk);
    opValid = 1'b0; loadEn = 1'b0;
    expectReg("R10 fill beside illegal op", 5'd29, 32'hAAAA_5555);
  endtask

  initial begin : watchdog
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testZeroReg();
    fillAll();
    testHalving();
    testSaturate();
    testSub();
    testIllegal();
    testNoValid();
    testReadDuringWrite();
    testCollision();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule